// File: doc/BRIEF.md
# Memory-Device RAS Error Status and Header Log

This block keeps the error status for a memory device. Uncorrectable errors enter an in-order queue; each queued error carries a type code and a header log of up to `HDR_WORDS` dwords. A first-error pointer field and a header-log register window always show the oldest queued error. The uncorrectable status register is the OR of the type bits of every queued error. Software clears errors by writing the status register. Writing exactly the pointed-to bit retires only the oldest error, so several headers can be recorded and read in turn. Any other pattern retires every queued error whose type bit it names.

Correctable errors are simpler: a mask-qualified sticky status bit per type, cleared by writing 1. Each unmasked injection of either class raises a one-cycle error-signal pulse on its own output, for a message transport outside this block.

Uncorrectable type codes 0 to 14 cover parity on cache and memory data, address and byte enables, data ECC on both, re-initialisation threshold, reserved encoding, poison received, receiver overflow, internal error and link-encryption transmit and receive errors. Correctable codes 0 to 6 cover data ECC on cache and memory, CRC and retry thresholds, poison received on cache and memory, and physical-layer errors.

Top module: `ras_err_log`

## Requirements
- R1: After reset, the uncorrectable status (word 0), uncorrectable mask (word 1), correctable status (word 2) and correctable mask (word 3) read 0. The capability word (word 4) reads 31: pointer bits [4:0] hold the unused value 31 and overflow bit 8 is 0. Both pulse outputs are low.
- R2: An uncorrectable injection is ignored when its type bit is set in the mask register or its type is 15 or higher. It causes no status change, no pointer change and no pulse. Mask bits above 14 always read 0.
- R3: Header dwords given before a commit are stored in order, up to `HDR_WORDS` of them, and later dwords are dropped. Word 32+i reads dword i of the oldest error, and reads 0 where no dword was given.
- R4: When the queue goes from empty to non-empty, the pointer takes the new error's type and the header window shows its header. Later injections leave both unchanged.
- R5: Writing word 0 with exactly the value 1 shifted left by the pointer removes only the oldest error. The pointer and header window then show the next error.
- R6: Writing word 0 with any other value removes every queued error whose type bit is set in that value. The remaining errors keep their order, and a value of 0 removes nothing.
- R7: When the queue becomes empty, the pointer reads 31 and the status reads 0.
- R8: The uncorrectable status always equals the OR of (1 << type) over the queued errors, including duplicate types.
- R9: Correctable status bit t is set by an injection of type t only when mask bit t is clear and t is below 7. Writing 1 to a status bit clears it.
- R10: An unmasked uncorrectable injection while `DEPTH` errors are queued is dropped and sets overflow bit 8 of word 4. Writing 1 to that bit clears it.
- R11: `irq_unc` pulses high for one cycle after each unmasked uncorrectable injection, including one dropped for overflow. `irq_cor` does the same for correctable injections, and neither class drives the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address; the upper half is the header window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the address presented one cycle earlier |
| unc_hdr_we | input | 1 | Header dword strobe for the error being built |
| unc_hdr_data | input | 32 | Header dword |
| unc_inj_valid | input | 1 | Commit an uncorrectable error |
| unc_inj_type | input | 5 | Uncorrectable type code |
| cor_inj_valid | input | 1 | Inject a correctable error |
| cor_inj_type | input | 3 | Correctable type code |
| irq_unc | output | 1 | Uncorrectable error-signal pulse |
| irq_cor | output | 1 | Correctable error-signal pulse |

## Verification
On every cycle the assertions check that the queue count never exceeds its depth and that the occupied header slots match the count. They also check that a non-empty queue has the pointed-to status bit set, that an empty queue shows the unused pointer and zero status, and that overflow only rises from a full queue. Further cycle checks cover masked correctable bits, which never rise, and pulses, which only follow an injection. The ordering behaviour can only be shown by the bench's scenarios. That covers the head-only pop against the pattern removal, header reload from the new head, truncation to the header size, and duplicate types surviving a pop.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int UNC_TYPES = 15;
  localparam int COR_TYPES = 7;
  localparam int TYPE_W    = 5;
  localparam int COR_TW    = 3;
  localparam logic [TYPE_W-1:0] PTR_NONE = 5'd31;
  localparam logic [31:0] UNC_VALID = (32'd1 << UNC_TYPES) - 32'd1;
  localparam int REG_UNC_STS = 0;
  localparam int REG_UNC_MSK = 1;
  localparam int REG_COR_STS = 2;
  localparam int REG_COR_MSK = 3;
  localparam int REG_CAP     = 4;
  localparam int OVF_BIT     = 8;
endpackage

// File: rtl/ras_hdr_ram.sv
module ras_hdr_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 ** AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ras_cor_status.sv
module ras_cor_status #(
  parameter int NTYPES = 7,
  parameter int TW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inj_valid,
  input  logic [TW-1:0]     inj_type,
  input  logic [NTYPES-1:0] mask,
  input  logic              clr_we,
  input  logic [NTYPES-1:0] clr_val,
  output logic [NTYPES-1:0] status,
  output logic              hit
);
  localparam int SW = 2 ** TW;
  logic [SW-1:0]     onehot;
  logic [NTYPES-1:0] set_v;

  always_comb begin
    onehot = SW'(1) << inj_type;
    set_v  = inj_valid ? (onehot[NTYPES-1:0] & ~mask) : '0;
    hit    = |set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~(clr_we ? clr_val : '0)) | set_v;
  end

  // R9
  cor_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & $past(mask)) == '0);
endmodule

// File: rtl/ras_unc_queue.sv
module ras_unc_queue
  import ras_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HDR_WORDS = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hdr_we,
  input  logic [31:0]                  hdr_data,
  input  logic                         inj_valid,
  input  logic [TYPE_W-1:0]            inj_type,
  input  logic [31:0]                  mask,
  input  logic                         clr_we,
  input  logic [31:0]                  clr_val,
  input  logic                         ovf_clr,
  input  logic [$clog2(HDR_WORDS)-1:0] hdr_idx,
  output logic [31:0]                  hdr_rdata,
  output logic [31:0]                  status,
  output logic [TYPE_W-1:0]            fep,
  output logic                         overflow,
  output logic                         hit
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int IDX_W  = $clog2(HDR_WORDS);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LEN_W  = IDX_W + 1;

  logic [TYPE_W-1:0] q_type [DEPTH];
  logic [SLOT_W-1:0] q_slot [DEPTH];
  logic [LEN_W-1:0]  q_len  [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [DEPTH-1:0]  busy;
  logic              stage_vld;
  logic [SLOT_W-1:0] stage_slot;
  logic [LEN_W-1:0]  hdr_cnt;

  logic [TYPE_W-1:0] n_type [DEPTH];
  logic [SLOT_W-1:0] n_slot [DEPTH];
  logic [LEN_W-1:0]  n_len  [DEPTH];
  logic [CNT_W-1:0]  n_cnt;
  logic [DEPTH-1:0]  n_busy, freed, keep;
  logic [31:0]       n_status;
  logic [SLOT_W-1:0] free_slot, eff_slot;
  logic              free_any, word_ok, push, drop, pop_mode;
  logic [31:0]       ram_q;
  logic              rd_ok_q;

  always_comb begin
    free_slot = '0;
    free_any  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_slot = SLOT_W'(i);
        free_any  = 1'b1;
      end
    end
    eff_slot = stage_vld ? stage_slot : free_slot;
    word_ok  = hdr_we && (hdr_cnt < LEN_W'(HDR_WORDS)) && (stage_vld || free_any);
    hit      = inj_valid && |((32'd1 << inj_type) & ~mask & UNC_VALID);
    push     = hit && (cnt < CNT_W'(DEPTH));
    drop     = hit && (cnt == CNT_W'(DEPTH));
    pop_mode = clr_we && (cnt != '0) && (clr_val == (32'd1 << fep));
  end

  always_comb begin
    logic [CNT_W-1:0] k;
    k      = '0;
    n_type = q_type;
    n_slot = q_slot;
    n_len  = q_len;
    freed  = '0;
    keep   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt) begin
        keep[i] = !(clr_we && (pop_mode ? (i == 0) : clr_val[q_type[i]]));
        if (keep[i]) begin
          n_type[k[SLOT_W-1:0]] = q_type[i];
          n_slot[k[SLOT_W-1:0]] = q_slot[i];
          n_len[k[SLOT_W-1:0]]  = q_len[i];
          k = k + 1'b1;
        end else begin
          freed[q_slot[i]] = 1'b1;
        end
      end
    end
    if (push) begin
      n_type[k[SLOT_W-1:0]] = inj_type;
      n_slot[k[SLOT_W-1:0]] = eff_slot;
      n_len[k[SLOT_W-1:0]]  = hdr_cnt + LEN_W'(word_ok);
      k = k + 1'b1;
    end
    n_cnt  = k;
    n_busy = (busy & ~freed) | (push ? (DEPTH'(1) << eff_slot) : '0);
    n_status = '0;
    for (int j = 0; j < DEPTH; j++)
      if (CNT_W'(j) < n_cnt) n_status = n_status | (32'd1 << n_type[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        q_type[i] <= '0;
        q_slot[i] <= '0;
        q_len[i]  <= '0;
      end
      cnt        <= '0;
      busy       <= '0;
      status     <= '0;
      fep        <= PTR_NONE;
      overflow   <= 1'b0;
      stage_vld  <= 1'b0;
      stage_slot <= '0;
      hdr_cnt    <= '0;
    end else begin
      q_type   <= n_type;
      q_slot   <= n_slot;
      q_len    <= n_len;
      cnt      <= n_cnt;
      busy     <= n_busy;
      status   <= n_status;
      fep      <= (n_cnt != '0) ? n_type[0] : PTR_NONE;
      overflow <= (overflow & ~ovf_clr) | drop;
      if (inj_valid) begin
        stage_vld <= 1'b0;
        hdr_cnt   <= '0;
      end else if (word_ok) begin
        stage_vld  <= 1'b1;
        stage_slot <= eff_slot;
        hdr_cnt    <= hdr_cnt + 1'b1;
      end
    end
  end

  ras_hdr_ram #(.AW(SLOT_W + IDX_W), .DW(32)) u_ram (
    .clk   (clk),
    .we    (word_ok),
    .waddr ({eff_slot, hdr_cnt[IDX_W-1:0]}),
    .wdata (hdr_data),
    .raddr ({q_slot[0], hdr_idx}),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_ok_q <= 1'b0;
    else     rd_ok_q <= (cnt != '0) && ({1'b0, hdr_idx} < q_len[0]);
  end
  assign hdr_rdata = rd_ok_q ? ram_q : '0;

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  // R8
  slot_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(busy) == int'(cnt));
  // R4
  head_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> status[fep]);
  // R7
  empty_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> (fep == PTR_NONE && status == '0));
  // R10
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(cnt) == CNT_W'(DEPTH));
endmodule

// File: rtl/ras_err_log.sv
module ras_err_log
  import ras_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HDR_WORDS = 32,
  parameter int ADDR_W    = $clog2(HDR_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              unc_hdr_we,
  input  logic [31:0]       unc_hdr_data,
  input  logic              unc_inj_valid,
  input  logic [TYPE_W-1:0] unc_inj_type,
  input  logic              cor_inj_valid,
  input  logic [COR_TW-1:0] cor_inj_type,
  output logic              irq_unc,
  output logic              irq_cor
);
  localparam int IDX_W = ADDR_W - 1;

  logic [31:0]          unc_mask;
  logic [COR_TYPES-1:0] cor_mask, cor_status;
  logic [31:0]          unc_status, hdr_rdata, reg_q;
  logic [TYPE_W-1:0]    fep;
  logic                 overflow, unc_hit, cor_hit, hdr_sel_q;
  logic                 in_regs, wr_unc_sts, wr_cor_sts, wr_cap;

  assign in_regs    = !reg_addr[ADDR_W-1];
  assign wr_unc_sts = reg_we && in_regs && reg_addr == ADDR_W'(REG_UNC_STS);
  assign wr_cor_sts = reg_we && in_regs && reg_addr == ADDR_W'(REG_COR_STS);
  assign wr_cap     = reg_we && in_regs && reg_addr == ADDR_W'(REG_CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      unc_mask <= '0;
      cor_mask <= '0;
    end else if (reg_we && in_regs) begin
      if (reg_addr == ADDR_W'(REG_UNC_MSK)) unc_mask <= reg_wdata & UNC_VALID;
      if (reg_addr == ADDR_W'(REG_COR_MSK)) cor_mask <= reg_wdata[COR_TYPES-1:0];
    end
  end

  ras_unc_queue #(.DEPTH(DEPTH), .HDR_WORDS(HDR_WORDS)) u_unc (
    .clk       (clk),
    .rst       (rst),
    .hdr_we    (unc_hdr_we),
    .hdr_data  (unc_hdr_data),
    .inj_valid (unc_inj_valid),
    .inj_type  (unc_inj_type),
    .mask      (unc_mask),
    .clr_we    (wr_unc_sts),
    .clr_val   (reg_wdata),
    .ovf_clr   (wr_cap && reg_wdata[OVF_BIT]),
    .hdr_idx   (reg_addr[IDX_W-1:0]),
    .hdr_rdata (hdr_rdata),
    .status    (unc_status),
    .fep       (fep),
    .overflow  (overflow),
    .hit       (unc_hit)
  );

  ras_cor_status #(.NTYPES(COR_TYPES), .TW(COR_TW)) u_cor (
    .clk       (clk),
    .rst       (rst),
    .inj_valid (cor_inj_valid),
    .inj_type  (cor_inj_type),
    .mask      (cor_mask),
    .clr_we    (wr_cor_sts),
    .clr_val   (reg_wdata[COR_TYPES-1:0]),
    .status    (cor_status),
    .hit       (cor_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      hdr_sel_q <= 1'b0;
      irq_unc   <= 1'b0;
      irq_cor   <= 1'b0;
    end else begin
      hdr_sel_q <= reg_addr[ADDR_W-1];
      irq_unc   <= unc_hit;
      irq_cor   <= cor_hit;
      case (int'(reg_addr))
        REG_UNC_STS: reg_q <= unc_status;
        REG_UNC_MSK: reg_q <= unc_mask;
        REG_COR_STS: reg_q <= 32'(cor_status);
        REG_COR_MSK: reg_q <= 32'(cor_mask);
        REG_CAP:     reg_q <= {23'd0, overflow, 3'd0, fep};
        default:     reg_q <= '0;
      endcase
    end
  end

  assign reg_rdata = hdr_sel_q ? hdr_rdata : reg_q;

  // R11
  irq_unc_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_unc |-> $past(unc_inj_valid));
  // R11
  irq_cor_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_cor |-> $past(cor_inj_valid));
endmodule

// File: tb/ras_err_log_bench.sv
`timescale 1ns/100ps
module ras_err_log_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        unc_hdr_we = 1'b0;
  logic [31:0] unc_hdr_data = '0;
  logic        unc_inj_valid = 1'b0;
  logic [4:0]  unc_inj_type = '0;
  logic        cor_inj_valid = 1'b0;
  logic [2:0]  cor_inj_type = '0;
  logic        irq_unc, irq_cor;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ras_err_log u_ras_err_log (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .unc_hdr_we(unc_hdr_we), .unc_hdr_data(unc_hdr_data),
    .unc_inj_valid(unc_inj_valid), .unc_inj_type(unc_inj_type),
    .cor_inj_valid(cor_inj_valid), .cor_inj_type(cor_inj_type),
    .irq_unc(irq_unc), .irq_cor(irq_cor)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 inject uncorrectable, 1 write, 2 read
    logic [7:0]  a;    // type or address
    logic [31:0] d;    // header count or write data
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'd3,    32'd2,    32'd0,          4'd4},
    '{2'd0, 8'd7,    32'd1,    32'd0,          4'd4},
    '{2'd0, 8'd3,    32'd0,    32'd0,          4'd8},
    '{2'd2, 8'd0,    32'd0,    32'h0000_0088,  4'd8},
    '{2'd2, 8'd4,    32'd0,    32'd3,          4'd4},
    '{2'd2, 8'd32,   32'd0,    32'hA000_0300,  4'd3},
    '{2'd2, 8'd33,   32'd0,    32'hA000_0301,  4'd3},
    '{2'd2, 8'd34,   32'd0,    32'd0,          4'd3},
    '{2'd1, 8'd0,    32'h8,    32'd0,          4'd5},
    '{2'd2, 8'd4,    32'd0,    32'd7,          4'd5},
    '{2'd2, 8'd32,   32'd0,    32'hA000_0700,  4'd5},
    '{2'd2, 8'd0,    32'd0,    32'h0000_0088,  4'd8},
    '{2'd1, 8'd0,    32'h8,    32'd0,          4'd6},
    '{2'd2, 8'd4,    32'd0,    32'd7,          4'd6},
    '{2'd2, 8'd0,    32'd0,    32'h0000_0080,  4'd6},
    '{2'd1, 8'd0,    32'h80,   32'd0,          4'd7},
    '{2'd2, 8'd4,    32'd0,    32'd31,         4'd7},
    '{2'd2, 8'd0,    32'd0,    32'd0,          4'd7}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string rq);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1;
    chk(rq, reg_rdata, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic inj_unc(input logic [4:0] t, input int n, input logic exp_irq, input string rq);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      unc_hdr_we = 1'b1;
      unc_hdr_data = 32'hA000_0000 | (32'(t) << 8) | 32'(k);
    end
    @(negedge clk);
    unc_hdr_we = 1'b0; unc_inj_valid = 1'b1; unc_inj_type = t;
    @(posedge clk); #1;
    chk(rq, {31'd0, irq_unc}, {31'd0, exp_irq});
    chk("R11 cor quiet", {31'd0, irq_cor}, 32'd0);
    @(negedge clk); unc_inj_valid = 1'b0;
    @(posedge clk); #1;
    chk("R11 pulse end", {31'd0, irq_unc}, 32'd0);
  endtask

  task automatic inj_cor(input logic [2:0] t, input logic exp_irq);
    @(negedge clk); cor_inj_valid = 1'b1; cor_inj_type = t;
    @(posedge clk); #1;
    chk("R11 cor pulse", {31'd0, irq_cor}, {31'd0, exp_irq});
    chk("R11 unc quiet", {31'd0, irq_unc}, 32'd0);
    @(negedge clk); cor_inj_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    rd(6'd0, 32'd0, "R1 unc status");
    rd(6'd1, 32'd0, "R1 unc mask");
    rd(6'd2, 32'd0, "R1 cor status");
    rd(6'd3, 32'd0, "R1 cor mask");
    rd(6'd4, 32'd31, "R1 cap");
    chk("R1 irq", {30'd0, irq_unc, irq_cor}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = $sformatf("R%0d vec %0d", TBL[v].req, v);
      case (TBL[v].op)
        2'd0: inj_unc(TBL[v].a[4:0], int'(TBL[v].d), 1'b1, rq);
        2'd1: wr(TBL[v].a[5:0], TBL[v].d);
        default: rd(TBL[v].a[5:0], TBL[v].exp, rq);
      endcase
    end

    // R2 masked and out-of-range uncorrectable types
    wr(6'd1, 32'hFFFF_FFE0 | 32'h20);
    rd(6'd1, 32'h0000_7FE0, "R2 mask readback");
    wr(6'd1, 32'h20);
    inj_unc(5'd5, 1, 1'b0, "R2 masked irq");
    rd(6'd0, 32'd0, "R2 masked status");
    rd(6'd4, 32'd31, "R2 masked pointer");
    inj_unc(5'd20, 0, 1'b0, "R2 bad type irq");
    rd(6'd0, 32'd0, "R2 bad type status");
    wr(6'd1, 32'd0);

    // R3 header truncation
    inj_unc(5'd2, 34, 1'b1, "R3 long header irq");
    inj_unc(5'd4, 0, 1'b1, "R3 empty header irq");
    rd(6'd63, 32'hA000_021F, "R3 last kept dword");
    rd(6'd32, 32'hA000_0200, "R3 first dword");
    wr(6'd0, 32'h4);
    rd(6'd4, 32'd4, "R5 pointer after pop");
    rd(6'd32, 32'd0, "R3 extra dwords dropped");
    wr(6'd0, 32'h10);
    rd(6'd4, 32'd31, "R7 empty pointer");

    // R9 correctable status
    inj_cor(3'd2, 1'b1);
    rd(6'd2, 32'h4, "R9 cor set");
    wr(6'd3, 32'h20);
    inj_cor(3'd5, 1'b0);
    rd(6'd2, 32'h4, "R9 cor masked");
    inj_cor(3'd7, 1'b0);
    rd(6'd2, 32'h4, "R9 cor bad type");
    wr(6'd2, 32'h4);
    rd(6'd2, 32'd0, "R9 cor w1c");

    // R10 overflow
    for (int i = 0; i < 8; i++) inj_unc(5'd1, 0, 1'b1, "R10 fill irq");
    rd(6'd4, 32'd1, "R10 full no ovf");
    inj_unc(5'd1, 0, 1'b1, "R11 dropped still pulses");
    rd(6'd4, 32'h101, "R10 ovf set");
    wr(6'd0, 32'h2);
    rd(6'd0, 32'h2, "R8 duplicates remain");
    wr(6'd4, 32'h100);
    rd(6'd4, 32'd1, "R10 ovf cleared");
    wr(6'd0, 32'd0);
    rd(6'd0, 32'h2, "R6 zero removes none");
    wr(6'd0, 32'h3);
    rd(6'd4, 32'd31, "R6 all type removed");
    rd(6'd0, 32'd0, "R7 status empty");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule